// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a UART currently reports and drives the interrupt request line from that decision. It looks at five candidate sources: receiver line errors, received data reaching a fill threshold, a receive character timeout, the transmit holding register having emptied, and modem status changes. It ranks them in a fixed order and presents a 4-bit identification code. The interrupt line is active whenever that code is anything other than "no interrupt".

Two pieces of state live inside the block. The first is a character-timeout counter. It counts ticks while received data waits unread, and its limit is a fixed multiple of the configured character duration. The second is a transmit-empty pending flag. This flag clears itself when software reads the identification register while the transmit-empty source is the one reported, or when software writes a new byte into the holding register. The data path, the FIFOs and the serializers sit outside this block. They feed it counts, status bits and event strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset, the code is 0x1, `irq` is low, the transmit-empty pending flag is cleared and the timeout counter is zero.
- R2: When `int_enable[2]` is 1 and any bit of `line_err` is 1, the code is 0x6. This source outranks all others.
- R3: When `int_enable[0]` is 1, `rx_ready` is 1 and `rx_level` is at least the threshold chosen by `trig_sel` (0→1, 1→4, 2→8, 3→14 entries), the code is 0x4, unless R2 applies.
- R4: When `int_enable[0]` is 1, `rx_level` is non-zero and the timeout counter is at least 4×`char_ticks`, the code is 0xC, unless R2 or R3 applies. With `rx_level` zero, no timeout is reported.
- R5: The timeout counter goes to zero on the clock edge after `rx_push` or `rx_pop` is high. Otherwise it rises by one at each edge where `rx_ready` is high, until it reaches its limit. It holds its value while `rx_ready` is low.
- R6: A `thr_drained` pulse sets the transmit-empty pending flag at the next edge. While the flag is set and `int_enable[1]` is 1, the code is 0x2, unless R2, R3 or R4 applies.
- R7: The pending flag is cleared at the edge after `thr_write` is high. It is also cleared at the edge after `iir_read` is high while the code is 0x2. If a clear and `thr_drained` arrive in the same cycle, the clear wins.
- R8: An `iir_read` while the code is anything other than 0x2 leaves the pending flag set.
- R9: When `int_enable[3]` is 1 and any bit of `modem_delta` is 1, the code is 0x0, unless a higher source applies.
- R10: The ranking from highest to lowest is line status, data available, timeout, transmit empty, modem status. With no qualifying source the code is 0x1. `irq` is high exactly when the code is not 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_enable | input | 4 | Source enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line status, bit3 modem |
| line_err | input | 4 | Overrun, parity, framing and break error bits |
| rx_ready | input | 1 | Receive data waiting |
| rx_level | input | CNT_W | Receive FIFO fill count |
| rx_push | input | 1 | A character entered the receive FIFO this cycle |
| rx_pop | input | 1 | A character was read from the receive FIFO this cycle |
| trig_sel | input | 2 | Receive threshold select |
| char_ticks | input | CHAR_W | Ticks per character |
| thr_drained | input | 1 | Holding register went from full to empty this cycle |
| thr_write | input | 1 | Software wrote the holding register |
| iir_read | input | 1 | Software read the identification register |
| modem_delta | input | 4 | Modem status change bits |
| iir_code | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The ranking logic is swept over every enable mask combined with present or absent line errors, ready state, four fill levels, every threshold select and present or absent modem deltas. This shows whether each source wins only when it should and whether the thresholds sit at the exact entry counts. Directed sequences then step the timeout counter one edge short of its limit and onto it, pause it by dropping the ready input, and restart it with push and pop strobes, which separates counting from holding and resetting. A separate set of sequences raises and clears the transmit-empty flag by write, by a qualifying read, by a read that does not qualify because a higher source is shown, and by a simultaneous set and clear.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_TXEMPTY = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_code_e;

    localparam int IE_RX    = 0;
    localparam int IE_TX    = 1;
    localparam int IE_LINE  = 2;
    localparam int IE_MODEM = 3;

    localparam int NUM_SRC = 5;

    // Packed with the highest-ranked source in the most significant bit.
    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txempty;
        logic modem;
    } src_req_t;

    function automatic iid_code_e src_code(input int idx);
        case (idx)
            4:       return IID_LINE;
            3:       return IID_RXDATA;
            2:       return IID_TIMEOUT;
            1:       return IID_TXEMPTY;
            default: return IID_MODEM;
        endcase
    endfunction

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/uart_iid_timeout.sv
module uart_iid_timeout
    import uart_iid_pkg::*;
#(
    parameter int CHAR_W = 12,
    parameter int MULT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_ready,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic [CHAR_W-1:0] char_ticks,
    output logic              expired
);
    localparam int CW = CHAR_W + $clog2(MULT) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit   = CW'(char_ticks) * CW'(MULT);
    assign expired = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (rx_push || rx_pop) begin
            cnt <= '0;
        end else if (rx_ready && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: a FIFO access restarts the count
    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_push || rx_pop) |=> (cnt == '0));

    // R5: without data waiting and without access the count holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && !rx_push && !rx_pop) |=> $stable(cnt));

endmodule

// File: rtl/uart_iid_thre.sv
module uart_iid_thre
    import uart_iid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic thr_drained,
    input  logic thr_write,
    input  logic iir_read,
    input  logic shown_tx,
    output logic pending
);
    logic clr;

    assign clr = thr_write || (iir_read && shown_tx);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (clr) begin
            pending <= 1'b0;
        end else if (thr_drained) begin
            pending <= 1'b1;
        end
    end

    // R6: the flag only rises after a drain event
    assert_set_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(thr_drained));

    // R7: a holding-register write always clears
    assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
        thr_write |=> !pending);

    // R8: a read that does not show this source leaves it pending
    assert_read_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (pending && iir_read && !shown_tx && !thr_write) |=> pending);

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
(
    input  src_req_t  req,
    output iid_code_e code
);
    // Ascending scan: the highest-ranked active source is assigned last.
    always_comb begin
        code = IID_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                code = src_code(i);
            end
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_iid_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int CHAR_W = 12,
    parameter int MULT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        int_enable,
    input  logic [3:0]        line_err,
    input  logic              rx_ready,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic [1:0]        trig_sel,
    input  logic [CHAR_W-1:0] char_ticks,
    input  logic              thr_drained,
    input  logic              thr_write,
    input  logic              iir_read,
    input  logic [3:0]        modem_delta,
    output logic [3:0]        iir_code,
    output logic              irq
);
    src_req_t  req;
    iid_code_e code;
    logic      to_expired;
    logic      tx_pending;

    uart_iid_timeout #(
        .CHAR_W (CHAR_W),
        .MULT   (MULT)
    ) u_timeout (
        .clk        (clk),
        .rst        (rst),
        .rx_ready   (rx_ready),
        .rx_push    (rx_push),
        .rx_pop     (rx_pop),
        .char_ticks (char_ticks),
        .expired    (to_expired)
    );

    uart_iid_thre u_thre (
        .clk         (clk),
        .rst         (rst),
        .thr_drained (thr_drained),
        .thr_write   (thr_write),
        .iir_read    (iir_read),
        .shown_tx    (code == IID_TXEMPTY),
        .pending     (tx_pending)
    );

    always_comb begin
        req.line    = int_enable[IE_LINE] && (|line_err);
        req.rxdata  = int_enable[IE_RX] && rx_ready
                      && (int'(rx_level) >= int'(trig_level(trig_sel)));
        req.timeout = int_enable[IE_RX] && (rx_level != '0) && to_expired;
        req.txempty = int_enable[IE_TX] && tx_pending;
        req.modem   = int_enable[IE_MODEM] && (|modem_delta);
    end

    uart_iid_prio u_prio (
        .req  (req),
        .code (code)
    );

    assign iir_code = code;
    assign irq      = (code != IID_NONE);

    // R2: an enabled line error is always the reported source
    assert_line_top_R2: assert property (@(posedge clk) disable iff (rst)
        (int_enable[IE_LINE] && (|line_err)) |-> (iir_code == IID_LINE));

    // R9: with only modem enabled, a delta is reported as modem status
    assert_modem_only_R9: assert property (@(posedge clk) disable iff (rst)
        ((int_enable == 4'b1000) && (|modem_delta)) |-> (iir_code == IID_MODEM));

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  int_enable;
    logic [3:0]  line_err;
    logic        rx_ready;
    logic [4:0]  rx_level;
    logic        rx_push;
    logic        rx_pop;
    logic [1:0]  trig_sel;
    logic [11:0] char_ticks;
    logic        thr_drained;
    logic        thr_write;
    logic        iir_read;
    logic [3:0]  modem_delta;
    logic [3:0]  iir_code;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    uart_irq_ident uut (
        .clk(clk), .rst(rst), .int_enable(int_enable), .line_err(line_err),
        .rx_ready(rx_ready), .rx_level(rx_level), .rx_push(rx_push),
        .rx_pop(rx_pop), .trig_sel(trig_sel), .char_ticks(char_ticks),
        .thr_drained(thr_drained), .thr_write(thr_write), .iir_read(iir_read),
        .modem_delta(modem_delta), .iir_code(iir_code), .irq(irq)
    );

    task automatic check(input string req, input logic [3:0] exp);
        total++;
        if (iir_code !== exp || irq !== (exp != 4'h1)) begin
            bad++;
            $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b",
                     req, iir_code, irq, exp, (exp != 4'h1));
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] model(input logic [3:0] ie, input logic err,
        input logic rdy, input int lvl, input int tsel, input logic md);
        int thr;
        thr = (tsel == 0) ? 1 : (tsel == 1) ? 4 : (tsel == 2) ? 8 : 14;
        if (ie[2] && err)                 return 4'h6;
        if (ie[0] && rdy && lvl >= thr)   return 4'h4;
        if (ie[3] && md)                  return 4'h0;
        return 4'h1;
    endfunction

    function automatic string tag(input logic [3:0] c);
        case (c)
            4'h6:    return "R2 sweep";
            4'h4:    return "R3 sweep";
            4'h0:    return "R9 sweep";
            default: return "R10 sweep";
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int levels[4];
        logic [3:0] e;
        levels = '{0, 3, 8, 14};
        rst = 1'b1; int_enable = 4'h0; line_err = 4'h0; rx_ready = 1'b0;
        rx_level = 5'd0; rx_push = 1'b0; rx_pop = 1'b0; trig_sel = 2'd0;
        char_ticks = 12'd5; thr_drained = 1'b0; thr_write = 1'b0;
        iir_read = 1'b0; modem_delta = 4'h0;
        tick(2);
        rst = 1'b0;
        int_enable = 4'hF;
        #1;
        check("R1 reset", 4'h1);

        // Ranking sweep; push held so the timeout count stays at zero.
        rx_push = 1'b1;
        tick(1);
        for (int ie = 0; ie < 16; ie++)
            for (int er = 0; er < 2; er++)
                for (int rd = 0; rd < 2; rd++)
                    for (int li = 0; li < 4; li++)
                        for (int ts = 0; ts < 4; ts++)
                            for (int md = 0; md < 2; md++) begin
                                int_enable  = 4'(ie);
                                line_err    = er[0] ? 4'(1 << (ie % 4)) : 4'h0;
                                rx_ready    = rd[0];
                                rx_level    = 5'(levels[li]);
                                trig_sel    = 2'(ts);
                                modem_delta = md[0] ? 4'(1 << ts) : 4'h0;
                                #1;
                                e = model(4'(ie), er[0], rd[0], levels[li], ts, md[0]);
                                check(tag(e), e);
                            end
        line_err = 4'h0; modem_delta = 4'h0; rx_push = 1'b0;

        // Timeout: limit 4*2 = 8 ticks, level 2 below threshold 14.
        int_enable = 4'b0001; trig_sel = 2'd3; rx_level = 5'd2;
        char_ticks = 12'd2; rx_ready = 1'b1;
        rx_push = 1'b1; tick(1); rx_push = 1'b0;
        tick(7);
        check("R4 one tick short", 4'h1);
        tick(1);
        check("R4 at limit", 4'hC);
        rx_pop = 1'b1; tick(1); rx_pop = 1'b0;
        check("R5 pop restarts", 4'h1);
        tick(5);
        rx_ready = 1'b0;
        tick(10);
        rx_ready = 1'b1;
        tick(2);
        check("R5 held while not ready", 4'h1);
        tick(1);
        check("R5 resumes to limit", 4'hC);
        rx_level = 5'd0; #1;
        check("R4 empty fifo", 4'h1);
        rx_level = 5'd2; #1;
        check("R4 again", 4'hC);

        // Transmit empty flag.
        int_enable = 4'b0011;
        thr_drained = 1'b1; tick(1); thr_drained = 1'b0;
        check("R10 timeout over THRE", 4'hC);
        rx_ready = 1'b0;
        rx_pop = 1'b1; tick(1); rx_pop = 1'b0;
        check("R6 THRE shown", 4'h2);
        iir_read = 1'b1; tick(1); iir_read = 1'b0;
        check("R7 read clears", 4'h1);
        thr_drained = 1'b1; tick(1); thr_drained = 1'b0;
        check("R6 set again", 4'h2);
        thr_write = 1'b1; tick(1); thr_write = 1'b0;
        check("R7 write clears", 4'h1);
        thr_drained = 1'b1; thr_write = 1'b1; tick(1);
        thr_drained = 1'b0; thr_write = 1'b0;
        check("R7 clear wins", 4'h1);
        thr_drained = 1'b1; tick(1); thr_drained = 1'b0;
        int_enable = 4'b0111; line_err = 4'b0100; #1;
        check("R2 over THRE", 4'h6);
        iir_read = 1'b1; tick(1); iir_read = 1'b0;
        line_err = 4'h0; #1;
        check("R8 read of other source", 4'h2);
        int_enable = 4'hF; modem_delta = 4'b0010; #1;
        check("R10 THRE over modem", 4'h2);
        thr_write = 1'b1; tick(1); thr_write = 1'b0;
        check("R9 modem after clear", 4'h0);
        modem_delta = 4'h0;
        thr_drained = 1'b1; tick(1); thr_drained = 1'b0;
        rst = 1'b1; tick(1); rst = 1'b0;
        check("R1 reset clears flag", 4'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule